// File: doc/BRIEF.md
# NAND Hamming Parity Error Corrector

This block judges one 512-byte chunk of NAND data by its Hamming parity. The parity read back from the spare area and the parity the controller computed while streaming the chunk are presented together, each as three packed bytes. A start strobe makes the block reorder both words into a common lane order, XOR them into a 24-bit syndrome and classify the result. The result is one of three outcomes: a clean chunk, one flipped data bit (with its byte offset and bit index), or damage beyond repair. A stored parity of all ones marks an erased page, and an erased page with an all-zero computed parity is reported as clean.

The block never touches the data. An external write-back path reads the reported location and flips that bit in its buffer. Larger ECC sizes are handled as a run of consecutive chunks, and the block keeps a per-page tally. It counts how many chunks in the current page were repaired, raises a sticky flag if any chunk was beyond repair, and pulses a page-complete flag together with the result of the last chunk.

Top module: `nand_hecc_corrector`

## Requirements
- R1: After reset, status_o is 2'b00, err_byte_o and err_bit_o are zero, and done_o, page_done_o, page_bad_o and page_fixes_o are all zero.
- R2: done_o is high in exactly the cycle that follows each clock edge at which start_i is sampled high, and low otherwise.
- R3: When the stored and computed 24-bit parity words are equal, status_o is 2'b00 (clean).
- R4: Each parity word holds 12 lanes. Lane k (k = 0..11) has an even bit and an odd bit. The even bit is word bit k for k < 8 and word bit 16+(k-8) for k >= 8. The odd bit is word bit 8+k for k < 8 and word bit 20+(k-8) for k >= 8. Syndrome bit 2k is the XOR of the two even bits of lane k, and syndrome bit 2k+1 is the XOR of the two odd bits. A syndrome with exactly 12 set bits gives status 2'b01 (corrected). err_bit_o is then {s[5], s[3], s[1]}, and err_byte_o is {s[23], s[21], ..., s[9], s[7]}.
- R5: A syndrome with exactly 1 or exactly 11 set bits gives status 2'b10 (uncorrectable).
- R6: For any syndrome weight other than 1, 11 and 12, a stored word of 24'hFFFFFF together with a computed word of zero gives status 2'b00. Any other stored/computed pair at such a weight gives status 2'b10.
- R7: Any unequal pair whose syndrome weight is not 1, 11 or 12 and that is not an erased page gives status 2'b10.
- R8: err_byte_o and err_bit_o are zero whenever status_o is not 2'b01.
- R9: status_o, err_byte_o, err_bit_o and the page outputs hold their values in every cycle in which start_i is low, whatever the parity inputs do.
- R10: Chunks are grouped into pages of PAGE_CHUNKS (default 4), counted from reset. page_fixes_o counts the corrected chunks of the current page, including the latest one. page_bad_o is set once any chunk of the page is uncorrectable. Both start afresh with the first chunk of the next page. page_done_o is high together with done_o for the last chunk of each page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Judge the presented parity pair at this edge |
| stored_ecc_i | input | 24 | Parity read from the spare area, byte 0 in bits 7:0 |
| calc_ecc_i | input | 24 | Parity computed by the controller, same packing |
| status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| err_byte_o | output | 9 | Byte offset of the flipped bit within the chunk |
| err_bit_o | output | 3 | Bit index of the flipped bit within that byte |
| done_o | output | 1 | One-cycle result strobe |
| page_fixes_o | output | 3 | Corrected chunks so far in the current page |
| page_bad_o | output | 1 | Some chunk of the current page was uncorrectable |
| page_done_o | output | 1 | The result just given closes a page |

## Verification
Two functions can decide the same chunk. An erased-page stored word can still meet a computed word whose syndrome has weight 12, and in that case the single-bit rule must win over the erased rule. The bench provokes this with stored 24'hFFFFFF and a computed word chosen so that the syndrome names byte 0, bit 0, and expects a correction there. In the page tally, the closing strobe of a page falls in the same cycle as an uncorrectable verdict. The bench makes the fourth chunk of a page fail and checks that page_done_o, page_bad_o and the unchanged fix count all appear together with done_o.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;

  localparam int LANES  = 12;
  localparam int PAR_W  = 2 * LANES;
  localparam int WGT_W  = $clog2(PAR_W + 1);
  localparam int BIT_W  = 3;
  localparam int OFS_W  = LANES - BIT_W;
  localparam int FIX_WEIGHT = LANES;

  typedef enum logic [1:0] {
    HECC_CLEAN = 2'b00,
    HECC_FIXED = 2'b01,
    HECC_FATAL = 2'b10
  } hecc_status_e;

  // Number of set bits in a syndrome.
  function automatic logic [WGT_W-1:0] hecc_weight(input logic [PAR_W-1:0] s);
    logic [WGT_W-1:0] n;
    n = '0;
    for (int i = 0; i < PAR_W; i++) n = n + WGT_W'(s[i]);
    return n;
  endfunction

  // Bit index within the byte: odd lanes 2..0.
  function automatic logic [BIT_W-1:0] hecc_bit_index(input logic [PAR_W-1:0] s);
    logic [BIT_W-1:0] b;
    for (int k = 0; k < BIT_W; k++) b[k] = s[2*k+1];
    return b;
  endfunction

  // Byte offset within the chunk: odd lanes 11..3.
  function automatic logic [OFS_W-1:0] hecc_byte_offset(input logic [PAR_W-1:0] s);
    logic [OFS_W-1:0] o;
    for (int k = 0; k < OFS_W; k++) o[k] = s[2*(k+BIT_W)+1];
    return o;
  endfunction

endpackage

// File: rtl/hecc_lane_repack.sv
// Rebuilds a packed 3-byte parity word into lane order:
// output bit 2k = even parity of lane k, bit 2k+1 = odd parity of lane k.
module hecc_lane_repack
  import nand_hecc_pkg::*;
(
  input  logic [PAR_W-1:0] raw_i,
  output logic [PAR_W-1:0] lanes_o
);
  localparam int LOW_LANES = 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k < LOW_LANES) begin : g_low
      assign lanes_o[2*k]   = raw_i[k];
      assign lanes_o[2*k+1] = raw_i[LOW_LANES + k];
    end else begin : g_high
      assign lanes_o[2*k]   = raw_i[2*LOW_LANES + (k - LOW_LANES)];
      assign lanes_o[2*k+1] = raw_i[2*LOW_LANES + (LANES - LOW_LANES) + (k - LOW_LANES)];
    end
  end

endmodule

// File: rtl/hecc_classify.sv
// Combinational verdict on one chunk.
module hecc_classify
  import nand_hecc_pkg::*;
(
  input  logic [PAR_W-1:0] stored_i,
  input  logic [PAR_W-1:0] calc_i,
  input  logic [PAR_W-1:0] synd_i,
  output hecc_status_e     status_o,
  output logic [OFS_W-1:0] byte_o,
  output logic [BIT_W-1:0] bit_o,
  output logic [WGT_W-1:0] weight_o,
  output logic             erased_o
);
  logic is_match;
  logic calc_zero;

  assign is_match  = (stored_i == calc_i);
  assign erased_o  = &stored_i;
  assign calc_zero = (calc_i == '0);
  assign weight_o  = hecc_weight(synd_i);

  always_comb begin
    status_o = HECC_CLEAN;
    byte_o   = '0;
    bit_o    = '0;
    if (!is_match) begin
      if (weight_o == WGT_W'(FIX_WEIGHT)) begin
        status_o = HECC_FIXED;
        byte_o   = hecc_byte_offset(synd_i);
        bit_o    = hecc_bit_index(synd_i);
      end else if (weight_o == WGT_W'(1) || weight_o == WGT_W'(FIX_WEIGHT - 1)) begin
        status_o = HECC_FATAL;
      end else if (erased_o && calc_zero) begin
        status_o = HECC_CLEAN;
      end else begin
        status_o = HECC_FATAL;
      end
    end
  end

endmodule

// File: rtl/hecc_page_tally.sv
// Groups consecutive chunks into pages and accumulates their verdicts.
module hecc_page_tally #(
  parameter int PAGE_CHUNKS = 4,
  localparam int FIX_W = $clog2(PAGE_CHUNKS + 1),
  localparam int CNT_W = (PAGE_CHUNKS > 1) ? $clog2(PAGE_CHUNKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             fixed_i,
  input  logic             fatal_i,
  output logic [FIX_W-1:0] page_fixes_o,
  output logic             page_bad_o,
  output logic             page_done_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAGE_CHUNKS - 1);

  logic [CNT_W-1:0] chunk_idx;
  logic             first_chunk;
  logic             last_chunk;

  assign first_chunk = (chunk_idx == '0);
  assign last_chunk  = (chunk_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chunk_idx    <= '0;
      page_fixes_o <= '0;
      page_bad_o   <= 1'b0;
      page_done_o  <= 1'b0;
    end else begin
      page_done_o <= start_i && last_chunk;
      if (start_i) begin
        chunk_idx    <= last_chunk ? '0 : chunk_idx + CNT_W'(1);
        page_fixes_o <= (first_chunk ? '0 : page_fixes_o) + FIX_W'(fixed_i);
        page_bad_o   <= (first_chunk ? 1'b0 : page_bad_o) | fatal_i;
      end
    end
  end

  // R10: the tally never counts more repairs than a page has chunks
  a_r10_fix_bound: assert property (@(posedge clk) disable iff (!rst_n)
    page_fixes_o <= FIX_W'(PAGE_CHUNKS));

  // R10: a page closes only on a judged chunk
  a_r10_page_close: assert property (@(posedge clk) disable iff (!rst_n)
    page_done_o |-> $past(start_i));

  // R9: page state holds while idle
  a_r9_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(page_fixes_o) && $stable(page_bad_o));

endmodule

// File: rtl/nand_hecc_corrector.sv
module nand_hecc_corrector
  import nand_hecc_pkg::*;
#(
  parameter int PAGE_CHUNKS = 4,
  localparam int FIX_W = $clog2(PAGE_CHUNKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [23:0]      stored_ecc_i,
  input  logic [23:0]      calc_ecc_i,
  output logic [1:0]       status_o,
  output logic [8:0]       err_byte_o,
  output logic [2:0]       err_bit_o,
  output logic             done_o,
  output logic [FIX_W-1:0] page_fixes_o,
  output logic             page_bad_o,
  output logic             page_done_o
);
  logic [PAR_W-1:0] stored_lanes;
  logic [PAR_W-1:0] calc_lanes;
  logic [PAR_W-1:0] syndrome;
  hecc_status_e     verdict;
  logic [OFS_W-1:0] verdict_byte;
  logic [BIT_W-1:0] verdict_bit;
  logic [WGT_W-1:0] synd_weight;
  logic             erased_page;
  logic             chunk_fixed;
  logic             chunk_fatal;

  hecc_lane_repack u_rep_stored (.raw_i(stored_ecc_i), .lanes_o(stored_lanes));
  hecc_lane_repack u_rep_calc   (.raw_i(calc_ecc_i),   .lanes_o(calc_lanes));

  assign syndrome = stored_lanes ^ calc_lanes;

  hecc_classify u_classify (
    .stored_i (stored_ecc_i),
    .calc_i   (calc_ecc_i),
    .synd_i   (syndrome),
    .status_o (verdict),
    .byte_o   (verdict_byte),
    .bit_o    (verdict_bit),
    .weight_o (synd_weight),
    .erased_o (erased_page)
  );

  assign chunk_fixed = (verdict == HECC_FIXED);
  assign chunk_fatal = (verdict == HECC_FATAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o   <= HECC_CLEAN;
      err_byte_o <= '0;
      err_bit_o  <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        status_o   <= verdict;
        err_byte_o <= verdict_byte;
        err_bit_o  <= verdict_bit;
      end
    end
  end

  hecc_page_tally #(.PAGE_CHUNKS(PAGE_CHUNKS)) u_tally (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .fixed_i      (chunk_fixed),
    .fatal_i      (chunk_fatal),
    .page_fixes_o (page_fixes_o),
    .page_bad_o   (page_bad_o),
    .page_done_o  (page_done_o)
  );

  // R2: result strobe follows every start
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  a_r2_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i));

  // R3: equal parity words are clean
  a_r3_match_clean: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (stored_ecc_i == calc_ecc_i) |=> status_o == 2'b00);

  // R4: a repair verdict comes only from a weight-12 syndrome
  a_r4_fix_weight: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && status_o == 2'b01 |-> $past(synd_weight) == WGT_W'(FIX_WEIGHT));

  // R6: erased page against zero parity is clean
  a_r6_erased_clean: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && erased_page && calc_ecc_i == '0 |=> status_o == 2'b00);

  // R8: location is zero unless repaired
  a_r8_loc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != 2'b01 |-> err_byte_o == '0 && err_bit_o == '0);

  // R9: results hold while idle
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(status_o) && $stable(err_byte_o) && $stable(err_bit_o));

  // R10: page close rides on a result strobe
  a_r10_close_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    page_done_o |-> done_o);

endmodule

// File: tb/nand_hecc_corrector_test.sv
module nand_hecc_corrector_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] stored_ecc_i = '0;
  logic [23:0] calc_ecc_i = '0;
  logic [1:0]  status_o;
  logic [8:0]  err_byte_o;
  logic [2:0]  err_bit_o;
  logic        done_o;
  logic [2:0]  page_fixes_o;
  logic        page_bad_o;
  logic        page_done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nand_hecc_corrector uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .stored_ecc_i(stored_ecc_i), .calc_ecc_i(calc_ecc_i),
    .status_o(status_o), .err_byte_o(err_byte_o), .err_bit_o(err_bit_o),
    .done_o(done_o), .page_fixes_o(page_fixes_o),
    .page_bad_o(page_bad_o), .page_done_o(page_done_o)
  );

  // {stored, calc, expected status, expected byte, expected bit}
  localparam int NV = 11;
  localparam logic [61:0] VECS [NV] = '{
    {24'h3C3C3C, 24'h3C3C3C, 2'b00, 9'h000, 3'd0}, // R3 equal words
    {24'h0F00FF, 24'h000000, 2'b01, 9'h000, 3'd0}, // R4 byte 0 bit 0
    {24'hF0FF00, 24'h000000, 2'b01, 9'h1FF, 3'd7}, // R4 byte 511 bit 7
    {24'h5A2BD4, 24'h000000, 2'b01, 9'h0A5, 3'd3}, // R4 byte 165 bit 3
    {24'h481F82, 24'h123456, 2'b01, 9'h0A5, 3'd3}, // R4 same syndrome, nonzero calc
    {24'h000001, 24'h000000, 2'b10, 9'h000, 3'd0}, // R5 weight 1
    {24'h0007FF, 24'h000000, 2'b10, 9'h000, 3'd0}, // R5 weight 11
    {24'h000003, 24'h000000, 2'b10, 9'h000, 3'd0}, // R7 weight 2
    {24'hFFFFFF, 24'h000000, 2'b00, 9'h000, 3'd0}, // R6 erased, zero calc
    {24'hFFFFFF, 24'h000001, 2'b10, 9'h000, 3'd0}, // R6 erased, nonzero calc
    {24'hFFFFFF, 24'hF0FF00, 2'b01, 9'h000, 3'd0}  // R6 vs R4 overlap
  };

  function automatic string tag_of(input logic [1:0] st, input logic [23:0] stored);
    if (st == 2'b01) return "R4";
    if (stored == 24'hFFFFFF) return "R6";
    if (st == 2'b00) return "R3";
    return "R5/R7";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_chunk(input logic [23:0] st, input logic [23:0] ca);
    @(negedge clk);
    stored_ecc_i = st;
    calc_ecc_i   = ca;
    start_i      = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "status", int'(status_o), 0);
    check("R1", "byte", int'(err_byte_o), 0);
    check("R1", "bit", int'(err_bit_o), 0);
    check("R1", "done", int'(done_o), 0);
    check("R1", "page", int'({page_fixes_o, page_bad_o, page_done_o}), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [23:0] st;
      logic [23:0] ca;
      logic [1:0]  es;
      logic [8:0]  eb;
      logic [2:0]  ei;
      {st, ca, es, eb, ei} = VECS[i];
      run_chunk(st, ca);
      check("R2", "done high", int'(done_o), 1);
      check(tag_of(es, st), "status", int'(status_o), int'(es));
      check(es == 2'b01 ? "R4" : "R8", "byte", int'(err_byte_o), int'(eb));
      check(es == 2'b01 ? "R4" : "R8", "bit", int'(err_bit_o), int'(ei));
      @(negedge clk);
      check("R2", "done low", int'(done_o), 0);
    end

    // R9: outputs hold without start while inputs change
    run_chunk(24'h5A2BD4, 24'h000000);
    stored_ecc_i = 24'h000001;
    calc_ecc_i   = 24'hABCDEF;
    repeat (4) @(negedge clk);
    check("R9", "status held", int'(status_o), 1);
    check("R9", "byte held", int'(err_byte_o), 'hA5);
    check("R9", "bit held", int'(err_bit_o), 3);
    check("R2", "no spurious done", int'(done_o), 0);

    // R2: back-to-back starts give back-to-back strobes
    @(negedge clk);
    stored_ecc_i = 24'h000003; calc_ecc_i = 24'h0; start_i = 1'b1;
    @(negedge clk);
    check("R2", "done first", int'(done_o), 1);
    check("R7", "status first", int'(status_o), 2);
    stored_ecc_i = 24'hF0FF00;
    @(negedge clk);
    start_i = 1'b0;
    check("R2", "done second", int'(done_o), 1);
    check("R4", "byte second", int'(err_byte_o), 'h1FF);

    // R10 page tally from a fresh reset
    do_reset();
    run_chunk(24'h0F00FF, 24'h0);
    check("R10", "fixes c0", int'(page_fixes_o), 1);
    check("R10", "bad c0", int'(page_bad_o), 0);
    check("R10", "pdone c0", int'(page_done_o), 0);
    run_chunk(24'h111111, 24'h111111);
    check("R10", "fixes c1", int'(page_fixes_o), 1);
    run_chunk(24'h5A2BD4, 24'h0);
    check("R10", "fixes c2", int'(page_fixes_o), 2);
    check("R10", "pdone c2", int'(page_done_o), 0);
    run_chunk(24'h000001, 24'h0);
    check("R10", "fixes c3", int'(page_fixes_o), 2);
    check("R10", "bad c3", int'(page_bad_o), 1);
    check("R10", "pdone c3", int'(page_done_o), 1);
    check("R10", "done with close", int'(done_o), 1);
    @(negedge clk);
    check("R10", "pdone drops", int'(page_done_o), 0);
    check("R9", "bad held", int'(page_bad_o), 1);
    run_chunk(24'hF0FF00, 24'h0);
    check("R10", "fixes new page", int'(page_fixes_o), 1);
    check("R10", "bad new page", int'(page_bad_o), 0);
    check("R10", "pdone new page", int'(page_done_o), 0);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule